// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block is a small in-order 32-bit processor core. Work flows through five stages: fetch, decode, execute, memory and write-back. Each stage is held in its own named set of pipeline registers. The core reads instructions from one port and reaches data memory through a second port. Each port has its own address bus. Active-low strobes mark a fetch being accepted, a data read and a data write. Both memories answer combinationally in the same cycle as the address.

A result is forwarded to the execute stage from either of the two stages behind it. A load followed at once by an instruction that needs the loaded value costs one stall cycle. The core decides branches and jumps in the execute stage. It does not squash younger instructions. The two instructions that follow any branch or jump always run, and the target is fetched after them. The assembler or compiler fills these two slots.

Top module: `pipe5_core`

## Requirements
- R1: While `rst` is high, `iFetchN`, `dRdN` and `dWrN` are high and `iAddr` equals `RESET_PC` (default 0x00400024). The first fetch after reset is from `RESET_PC`, and later fetches advance by 4.
- R2: Instruction fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0], immediate [15:0] (sign-extended) and jump index [25:0]. Opcode 0x00 selects a register-register operation, which writes rd with one of the following, chosen by funct: add (0x20), subtract (0x22), bitwise and (0x24), bitwise or (0x25), or signed set-less-than (0x2A).
- R3: Opcode 0x08 writes rt with rs plus the immediate. Opcode 0x23 loads a word into rt, and opcode 0x2B stores rt. Both use address rs plus the immediate. While such an access is in the memory stage, `dAddr` carries the address, and `dRdN` (load) or `dWrN` (store, with `dWdata` valid) is low.
- R4: Opcode 0x04 branches when rs equals rt, to the branch address + 4 + (immediate << 2). Opcode 0x02 jumps to {upper 4 bits of the jump address + 4, index, 2'b00}. In both cases the next two instructions in sequence always run, and fetch then continues at the target.
- R5: A result is usable by the very next instruction, and by the one after it, without any stall. This holds for ALU operands, branch comparison and store data.
- R6: A load whose rt is nonzero, followed directly by an instruction that reads that register, causes exactly one stall cycle. During that cycle `iFetchN` is high and `iAddr` is held. No other case stalls.
- R7: Register 0 always reads as zero. A write to it has no effect.
- R8: Any other opcode, and any other funct under opcode 0x00, is a no-op. It writes no register and makes no memory access.
- R9: An instruction that reads a register in the same cycle the register is written back gets the new value.
- R10: `dRdN` and `dWrN` are never low together. `iFetchN` is low in every cycle after reset in which a new instruction is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| iAddr | output | 32 | Instruction fetch address |
| iFetchN | output | 1 | Fetch accepted this cycle, active low |
| iData | input | 32 | Instruction word at `iAddr` |
| dAddr | output | 32 | Data word address |
| dWdata | output | 32 | Store data |
| dRdata | input | 32 | Load data at `dAddr` |
| dRdN | output | 1 | Data read strobe, active low |
| dWrN | output | 1 | Data write strobe, active low |

## Verification
A wrong program counter or wrong branch decision shows on `iAddr` in the cycle after the faulty instruction leaves execute. A missing or extra stall shifts the fetch sequence and the `iFetchN` pattern from that cycle on. A bad forward, bypass or register-0 write does not show at once. It appears as a wrong value on `dWdata`, or as a wrong load address on `dAddr`, when a later store or load that depends on it reaches the memory stage, usually within a few cycles. The bench predicts every fetch address, strobe and data access cycle by cycle from an instruction-level model, so the first divergence is reported where it happens.

// File: rtl/pipe5_pkg.sv
`timescale 1ns/1ps
package pipe5_pkg;
  localparam int XLEN = 32;
  localparam int RIDX = 5;
  localparam int NSRC = 2;

  typedef logic [XLEN-1:0] word_t;
  typedef logic [RIDX-1:0] ridx_t;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_JUMP  = 6'h02;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT} aluop_e;
  typedef enum logic [1:0] {FWD_REG, FWD_MEM, FWD_WB} fwd_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic   stall;
    fwd_e   fwdA;
    fwd_e   fwdB;
    aluop_e aluOp;
    logic   aluImm;
    logic   redirect;
    logic   jump;
    logic   memRd;
    logic   memWr;
    logic   wbEn;
    ridx_t  wbAddr;
  } ctl_t;

  function automatic logic knownFn(logic [5:0] fn);
    return fn == FN_ADD || fn == FN_SUB || fn == FN_AND || fn == FN_OR || fn == FN_SLT;
  endfunction

  // {write valid, register index}; register 0 never counts as a destination
  function automatic logic [RIDX:0] destOf(word_t ir);
    logic  wr;
    ridx_t a;
    wr = 1'b0;
    a  = '0;
    case (ir[31:26])
      OP_RTYPE: if (knownFn(ir[5:0])) begin wr = 1'b1; a = ir[15:11]; end
      OP_ADDI, OP_LOAD: begin wr = 1'b1; a = ir[20:16]; end
      default: ;
    endcase
    if (a == '0) wr = 1'b0;
    return {wr, a};
  endfunction

  function automatic logic readsRs(word_t ir);
    case (ir[31:26])
      OP_RTYPE: return knownFn(ir[5:0]);
      OP_ADDI, OP_LOAD, OP_STORE, OP_BEQ: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic readsRt(word_t ir);
    case (ir[31:26])
      OP_RTYPE: return knownFn(ir[5:0]);
      OP_STORE, OP_BEQ: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/pipe5_ctrl.sv
`timescale 1ns/1ps
module pipe5_ctrl
  import pipe5_pkg::*;
(
  input  word_t irD,
  input  word_t irX,
  input  word_t irM,
  input  word_t irW,
  input  logic  opEq,
  output ctl_t  ctl
);
  logic [RIDX:0] dstX, dstM, dstW;
  ridx_t srcX [NSRC];
  fwd_e  fwdSel [NSRC];
  logic  loadHaz;

  assign dstX = destOf(irX);
  assign dstM = destOf(irM);
  assign dstW = destOf(irW);
  assign srcX[0] = irX[25:21];
  assign srcX[1] = irX[20:16];

  // Forward select per execute operand: memory stage wins over write-back
  for (genvar g = 0; g < NSRC; g++) begin : g_fwd
    assign fwdSel[g] = (dstM[RIDX] && dstM[RIDX-1:0] == srcX[g]) ? FWD_MEM :
                       (dstW[RIDX] && dstW[RIDX-1:0] == srcX[g]) ? FWD_WB  : FWD_REG;
  end

  // Load in execute feeding the instruction in decode
  assign loadHaz = (irX[31:26] == OP_LOAD) && dstX[RIDX] &&
                   ((readsRs(irD) && irD[25:21] == dstX[RIDX-1:0]) ||
                    (readsRt(irD) && irD[20:16] == dstX[RIDX-1:0]));

  always_comb begin
    ctl          = '0;
    ctl.stall    = loadHaz;
    ctl.fwdA     = fwdSel[0];
    ctl.fwdB     = fwdSel[1];
    ctl.aluOp    = ALU_ADD;
    ctl.aluImm   = 1'b0;
    case (irX[31:26])
      OP_RTYPE: begin
        case (irX[5:0])
          FN_SUB:  ctl.aluOp = ALU_SUB;
          FN_AND:  ctl.aluOp = ALU_AND;
          FN_OR:   ctl.aluOp = ALU_OR;
          FN_SLT:  ctl.aluOp = ALU_SLT;
          default: ctl.aluOp = ALU_ADD;
        endcase
      end
      OP_ADDI, OP_LOAD, OP_STORE: ctl.aluImm = 1'b1;
      OP_BEQ: ctl.aluOp = ALU_SUB;
      default: ;
    endcase
    ctl.jump     = irX[31:26] == OP_JUMP;
    ctl.redirect = ctl.jump || (irX[31:26] == OP_BEQ && opEq);
    ctl.memRd    = irM[31:26] == OP_LOAD;
    ctl.memWr    = irM[31:26] == OP_STORE;
    ctl.wbEn     = dstW[RIDX];
    ctl.wbAddr   = dstW[RIDX-1:0];
  end
endmodule

// File: rtl/pipe5_dpath.sv
`timescale 1ns/1ps
module pipe5_dpath
  import pipe5_pkg::*;
#(
  parameter word_t RESET_PC = 32'h0040_0024,
  parameter int    NREG     = 32
) (
  input  logic  clk,
  input  logic  rst,
  input  ctl_t  ctl,
  input  word_t iData,
  input  word_t dRdata,
  output word_t iAddr,
  output word_t dAddr,
  output word_t dWdata,
  output word_t irD,
  output word_t irX,
  output word_t irM,
  output word_t irW,
  output logic  opEq
);
  localparam int STEP = XLEN / 8;

  // ---------------- fetch state
  word_t pcF;
  // ---------------- decode latches: IR / PC
  word_t pcD;
  // ---------------- execute latches: IRX / PCX / A / B
  word_t pcX, regA, regB;
  // ---------------- memory latches: IRM / ALUM / SMDR
  word_t aluM, smdr;
  // ---------------- write-back latches: IRW / ALUW
  word_t aluW;

  word_t gpr [NREG];
  word_t rdVal [NSRC];
  ridx_t rdIdx [NSRC];
  word_t opV [NSRC];
  fwd_e  opSel [NSRC];
  word_t immX, src2, aluY, brTarget, jTarget;

  // ================= IF
  always_ff @(posedge clk) begin
    if (rst)               pcF <= RESET_PC;
    else if (ctl.redirect) pcF <= ctl.jump ? jTarget : brTarget;
    else if (!ctl.stall)   pcF <= pcF + STEP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irD <= '0;
      pcD <= '0;
    end else if (!ctl.stall) begin
      irD <= iData;
      pcD <= pcF + STEP;
    end
  end

  // ================= ID: register read with same-cycle write-back bypass
  assign rdIdx[0] = irD[25:21];
  assign rdIdx[1] = irD[20:16];
  for (genvar g = 0; g < NSRC; g++) begin : g_rd
    assign rdVal[g] = (rdIdx[g] == '0) ? '0 :
                      (ctl.wbEn && ctl.wbAddr == rdIdx[g]) ? aluW : gpr[rdIdx[g]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irX  <= '0;
      pcX  <= '0;
      regA <= '0;
      regB <= '0;
    end else begin
      irX  <= ctl.stall ? '0 : irD;
      pcX  <= pcD;
      regA <= rdVal[0];
      regB <= rdVal[1];
    end
  end

  // ================= EX
  assign opSel[0] = ctl.fwdA;
  assign opSel[1] = ctl.fwdB;
  for (genvar g = 0; g < NSRC; g++) begin : g_op
    word_t latched;
    assign latched = (g == 0) ? regA : regB;
    assign opV[g]  = (opSel[g] == FWD_MEM) ? aluM :
                     (opSel[g] == FWD_WB)  ? aluW : latched;
  end

  assign immX     = {{(XLEN-16){irX[15]}}, irX[15:0]};
  assign src2     = ctl.aluImm ? immX : opV[1];
  assign opEq     = opV[0] == opV[1];
  assign brTarget = pcX + (immX << 2);
  assign jTarget  = {pcX[XLEN-1:28], irX[25:0], 2'b00};

  always_comb begin
    case (ctl.aluOp)
      ALU_SUB: aluY = opV[0] - src2;
      ALU_AND: aluY = opV[0] & src2;
      ALU_OR:  aluY = opV[0] | src2;
      ALU_SLT: aluY = {{(XLEN-1){1'b0}}, $signed(opV[0]) < $signed(src2)};
      default: aluY = opV[0] + src2;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irM  <= '0;
      aluM <= '0;
      smdr <= '0;
    end else begin
      irM  <= irX;
      aluM <= aluY;
      smdr <= opV[1];
    end
  end

  // ================= MEM
  assign dAddr  = aluM;
  assign dWdata = smdr;

  always_ff @(posedge clk) begin
    if (rst) begin
      irW  <= '0;
      aluW <= '0;
    end else begin
      irW  <= irM;
      aluW <= ctl.memRd ? dRdata : aluM;
    end
  end

  // ================= WB
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) gpr[i] <= '0;
    end else if (ctl.wbEn) begin
      gpr[ctl.wbAddr] <= aluW;
    end
  end

  assign iAddr = pcF;
endmodule

// File: rtl/pipe5_core.sv
`timescale 1ns/1ps
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter word_t RESET_PC = 32'h0040_0024,
  parameter int    NREG     = 32
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] iAddr,
  output logic        iFetchN,
  input  logic [31:0] iData,
  output logic [31:0] dAddr,
  output logic [31:0] dWdata,
  input  logic [31:0] dRdata,
  output logic        dRdN,
  output logic        dWrN
);
  ctl_t  ctl;
  word_t irD, irX, irM, irW;
  logic  opEq;

  pipe5_ctrl u_ctrl (
    .irD (irD),
    .irX (irX),
    .irM (irM),
    .irW (irW),
    .opEq(opEq),
    .ctl (ctl)
  );

  pipe5_dpath #(.RESET_PC(RESET_PC), .NREG(NREG)) u_dpath (
    .clk   (clk),
    .rst   (rst),
    .ctl   (ctl),
    .iData (iData),
    .dRdata(dRdata),
    .iAddr (iAddr),
    .dAddr (dAddr),
    .dWdata(dWdata),
    .irD   (irD),
    .irX   (irX),
    .irM   (irM),
    .irW   (irW),
    .opEq  (opEq)
  );

  assign iFetchN = rst | ctl.stall;
  assign dRdN    = rst | ~ctl.memRd;
  assign dWrN    = rst | ~ctl.memWr;
endmodule

// File: rtl/pipe5_core_chk.sv
`timescale 1ns/1ps
module pipe5_core_chk
  import pipe5_pkg::*;
#(
  parameter word_t RESET_PC = 32'h0040_0024
) (
  input logic  clk,
  input logic  rst,
  input word_t iAddr,
  input logic  dRdN,
  input logic  dWrN,
  input ctl_t  ctl,
  input word_t irD,
  input word_t irX
);
  p_first_fetch_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> iAddr == RESET_PC);

  p_slots_kept_r4: assert property (@(posedge clk) disable iff (rst)
    ctl.redirect |=> irX == $past(irD));

  p_one_stall_r6: assert property (@(posedge clk) disable iff (rst)
    ctl.stall |=> !ctl.stall && $stable(iAddr));

  p_bubble_r6: assert property (@(posedge clk) disable iff (rst)
    ctl.stall |=> irX == '0);

  p_no_r0_write_r7: assert property (@(posedge clk) disable iff (rst)
    ctl.wbEn |-> ctl.wbAddr != '0);

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(!dRdN && !dWrN));
endmodule

bind pipe5_core pipe5_core_chk #(.RESET_PC(RESET_PC)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .iAddr(iAddr),
  .dRdN (dRdN),
  .dWrN (dWrN),
  .ctl  (ctl),
  .irD  (irD),
  .irX  (irX)
);

// File: tb/pipe5_core_bench.sv
`timescale 1ns/1ps
module pipe5_core_bench;
  localparam logic [31:0] BASE = 32'h0040_0024;
  localparam int IWORDS = 32;
  localparam int DWORDS = 8;
  localparam int STEPS  = 140;
  localparam int RUNTO  = 120;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] iAddr, iData, dAddr, dWdata, dRdata;
  logic iFetchN, dRdN, dWrN;

  always #10 clk = ~clk;

  pipe5_core u_pipe5_core (
    .clk(clk), .rst(rst), .iAddr(iAddr), .iFetchN(iFetchN), .iData(iData),
    .dAddr(dAddr), .dWdata(dWdata), .dRdata(dRdata), .dRdN(dRdN), .dWrN(dWrN)
  );

  logic [31:0] imem [IWORDS];
  logic [31:0] dmem [DWORDS];

  function automatic logic [31:0] fetchWord(logic [31:0] a);
    if (a >= BASE && a < BASE + 4 * IWORDS) return imem[int'((a - BASE) >> 2)];
    return 32'h0;
  endfunction

  assign iData  = fetchWord(iAddr);
  assign dRdata = dmem[dAddr[4:2]];
  always @(posedge clk) if (!dWrN) dmem[dAddr[4:2]] <= dWdata;

  // ---------- encoders
  function automatic logic [31:0] rEnc(int fn, int rd, int rs, int rt);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
  endfunction
  function automatic logic [31:0] iEnc(int op, int rt, int rs, int imm);
    return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] jEnc(int idx);
    logic [31:0] a;
    a = BASE + 32'(4 * idx);
    return {6'h02, a[27:2]};
  endfunction

  // ---------- reference model (instruction level)
  logic [31:0] mreg [32];
  logic [31:0] mdm [DWORDS];
  logic [31:0] seqA [STEPS];
  logic [31:0] seqI [STEPS];
  bit          stallAt [STEPS + 2];
  logic [31:0] stAddrQ[$], stDataQ[$], ldAddrQ[$];

  function automatic bit aluFn(logic [5:0] f);
    return f == 6'h20 || f == 6'h22 || f == 6'h24 || f == 6'h25 || f == 6'h2A;
  endfunction
  function automatic bit usesRs(logic [31:0] ir);
    return (ir[31:26] == 0 && aluFn(ir[5:0])) || ir[31:26] == 6'h08 ||
           ir[31:26] == 6'h23 || ir[31:26] == 6'h2B || ir[31:26] == 6'h04;
  endfunction
  function automatic bit usesRt(logic [31:0] ir);
    return (ir[31:26] == 0 && aluFn(ir[5:0])) || ir[31:26] == 6'h2B || ir[31:26] == 6'h04;
  endfunction

  task automatic runModel();
    logic [31:0] pc, n1, n2, nn, ir, a, b, imm, res, tgt, ea;
    bit taken;
    for (int i = 0; i < 32; i++) mreg[i] = 0;
    pc = BASE; n1 = BASE + 4; n2 = BASE + 8;
    for (int k = 0; k < STEPS; k++) begin
      ir = fetchWord(pc);
      seqA[k] = pc; seqI[k] = ir;
      a = mreg[ir[25:21]]; b = mreg[ir[20:16]];
      imm = {{16{ir[15]}}, ir[15:0]};
      taken = 0; tgt = 0;
      case (ir[31:26])
        6'h00: if (aluFn(ir[5:0])) begin
          case (ir[5:0])
            6'h20: res = a + b;
            6'h22: res = a - b;
            6'h24: res = a & b;
            6'h25: res = a | b;
            default: res = ($signed(a) < $signed(b)) ? 1 : 0;
          endcase
          mreg[ir[15:11]] = res;
        end
        6'h08: mreg[ir[20:16]] = a + imm;
        6'h23: begin ea = a + imm; ldAddrQ.push_back(ea); mreg[ir[20:16]] = mdm[ea[4:2]]; end
        6'h2B: begin ea = a + imm; stAddrQ.push_back(ea); stDataQ.push_back(b); mdm[ea[4:2]] = b; end
        6'h04: if (a == b) begin taken = 1; tgt = pc + 4 + (imm << 2); end
        6'h02: begin taken = 1; tgt = {pc[31:28] + 4'd0, ir[25:0], 2'b00}; tgt[31:28] = (pc + 4) >> 28; end
        default: ;
      endcase
      mreg[0] = 0;
      nn = taken ? tgt : n2 + 4;
      pc = n1; n1 = n2; n2 = nn;
    end
    for (int k = 0; k < STEPS + 2; k++) stallAt[k] = 0;
    for (int k = 0; k + 1 < STEPS; k++)
      if (seqI[k][31:26] == 6'h23 && seqI[k][20:16] != 0 &&
          ((usesRs(seqI[k+1]) && seqI[k+1][25:21] == seqI[k][20:16]) ||
           (usesRt(seqI[k+1]) && seqI[k+1][20:16] == seqI[k][20:16])))
        stallAt[k + 2] = 1;
  endtask

  // ---------- checking
  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    // program
    for (int i = 0; i < IWORDS; i++) imem[i] = 0;
    imem[0]  = iEnc(8, 1, 0, 5);
    imem[1]  = iEnc(8, 2, 0, -3);
    imem[2]  = rEnc(6'h20, 3, 1, 2);
    imem[3]  = rEnc(6'h22, 4, 3, 1);
    imem[4]  = rEnc(6'h24, 5, 4, 1);
    imem[5]  = rEnc(6'h25, 6, 2, 3);
    imem[6]  = rEnc(6'h2A, 7, 2, 1);
    imem[7]  = iEnc(6'h2B, 3, 0, 0);
    imem[8]  = iEnc(6'h2B, 7, 0, 4);
    imem[9]  = iEnc(8, 0, 0, 9);
    imem[10] = iEnc(6'h2B, 0, 0, 8);
    imem[11] = iEnc(6'h23, 8, 0, 4);
    imem[12] = rEnc(6'h20, 9, 8, 1);
    imem[13] = iEnc(6'h2B, 9, 0, 12);
    imem[14] = 32'hFC00_0000;
    imem[15] = rEnc(6'h3F, 10, 1, 1);
    imem[16] = iEnc(6'h2B, 10, 0, 16);
    imem[17] = iEnc(6'h04, 1, 1, 4);
    imem[18] = iEnc(6'h2B, 1, 0, 20);
    imem[19] = iEnc(6'h2B, 2, 0, 24);
    imem[20] = iEnc(8, 11, 0, 77);
    imem[21] = iEnc(6'h2B, 11, 0, 28);
    imem[22] = iEnc(6'h04, 2, 1, 5);
    imem[23] = iEnc(6'h2B, 5, 0, 20);
    imem[24] = jEnc(27);
    imem[25] = iEnc(6'h2B, 6, 0, 24);
    imem[26] = iEnc(8, 12, 0, 11);
    imem[27] = iEnc(6'h23, 13, 0, 0);
    imem[28] = iEnc(6'h2B, 13, 0, 28);
    imem[29] = rEnc(6'h20, 14, 12, 12);
    imem[30] = iEnc(6'h2B, 14, 0, 0);
    imem[31] = jEnc(31);
    for (int i = 0; i < DWORDS; i++) begin
      dmem[i] = 32'hA000_0000 + 32'(i);
      mdm[i]  = dmem[i];
    end
    runModel();

    // reset phase
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); #1;
      chk(iFetchN && dRdN && dWrN, "R1 strobes high in reset", {29'd0, iFetchN, dRdN, dWrN}, 32'h7);
      chk(iAddr == BASE, "R1 reset fetch address", iAddr, BASE);
    end
    @(negedge clk);
    rst = 1'b0;

    begin
      int fIdx = 0;
      bit held = 0;
      for (int cyc = 0; cyc < 1000 && fIdx < RUNTO; cyc++) begin
        bit expStall;
        #1;
        expStall = stallAt[fIdx] && !held;
        chk(iFetchN == expStall, "R6 R10 fetch strobe", {31'd0, iFetchN}, {31'd0, expStall});
        chk(iAddr == seqA[fIdx], "R1 R4 R6 fetch address", iAddr, seqA[fIdx]);
        if (expStall) held = 1;
        else begin fIdx++; held = 0; end
        chk(dRdN || dWrN, "R10 exclusive data strobes", {30'd0, dRdN, dWrN}, 32'h1);
        if (!dWrN) begin
          if (stAddrQ.size() == 0) chk(0, "R8 unexpected store", dAddr, 32'h0);
          else begin
            logic [31:0] ea, ed;
            ea = stAddrQ.pop_front(); ed = stDataQ.pop_front();
            chk(dAddr == ea, "R3 store address", dAddr, ea);
            chk(dWdata == ed, "R2 R5 R7 R8 R9 store data", dWdata, ed);
          end
        end
        if (!dRdN) begin
          if (ldAddrQ.size() == 0) chk(0, "R8 unexpected load", dAddr, 32'h0);
          else begin
            logic [31:0] ea;
            ea = ldAddrQ.pop_front();
            chk(dAddr == ea, "R3 load address", dAddr, ea);
          end
        end
        @(negedge clk);
      end
      chk(fIdx >= RUNTO, "R4 fetch progress", 32'(fIdx), 32'(RUNTO));
    end
    chk(stAddrQ.size() == 0, "R3 R4 all stores seen", 32'(stAddrQ.size()), 0);
    chk(ldAddrQ.size() == 0, "R3 all loads seen", 32'(ldAddrQ.size()), 0);
    for (int i = 0; i < DWORDS; i++)
      chk(dmem[i] == mdm[i], "R2 R3 R4 R5 final data word", dmem[i], mdm[i]);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      nFail++;
      $display("FAIL R10 watchdog expired: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule